// File: doc/BRIEF.md
# Network Status Indicator Driver

This block drives the three status lamps of a 10 Mbit/s Ethernet controller: traffic, collision and link. Each lamp pin is active low and open drain, so the block only produces a drive-enable for each pin. A high enable means the pad pulls the pin low and the lamp lights. A low enable means the pin is released and the lamp is dark.

Traffic and collision events are often one clock long. The block stretches each event into a visible pulse of about 50 ms with a down-counter, and the pulse length is a parameter in clock cycles. Any new event restarts the full interval, so steady traffic keeps the lamp lit without flicker.

The link lamp is decoded from four inputs: the media selection, the link-test enable, the link-integrity status and a function-enable bit from configuration. The decoded value passes through one output register.

Top module: `net_status_led`

## Requirements
- R1: While `rst_n` is low, all three drive-enables are 0 and both stretch counters are cleared.
- R2: A high `tx_evt` or a high `rx_evt` sampled on a rising clock edge sets `act_drv` to 1 from that edge on. It stays 1 for exactly `STRETCH_CYC` cycles after the last edge that sampled a trigger, and then returns to 0.
- R3: A trigger that arrives while a stretch is running reloads the full `STRETCH_CYC` length. A trigger held high keeps the output at 1 without a gap.
- R4: A high `col_evt` sampled on a rising edge drives `col_drv` in the same way, for `STRETCH_CYC` cycles. The two stretchers do not affect each other.
- R5: When `media_tp` is 0 (AUI medium selected), `link_drv` is 0.
- R6: When `media_tp` is 1, `link_test_en` is 1 and `link_led_en` is 1, `link_drv` equals `link_ok`.
- R7: When `media_tp` is 1, `link_test_en` is 0 and `link_led_en` is 1, `link_drv` is 1 whatever the value of `link_ok`.
- R8: When `link_led_en` is 0, `link_drv` is 0 for any values of the other inputs.
- R9: `link_drv` takes the value decoded from its inputs exactly one rising edge after those inputs are presented.
- R10: The traffic and collision lamps behave the same whether `media_tp` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_evt | input | 1 | Transmit activity strobe or level |
| rx_evt | input | 1 | Receive activity strobe or level |
| col_evt | input | 1 | Collision detect strobe or level |
| media_tp | input | 1 | 1 = twisted pair, 0 = AUI |
| link_ok | input | 1 | Link integrity good (already synchronised) |
| link_test_en | input | 1 | Link integrity testing enabled |
| link_led_en | input | 1 | Link lamp function enabled |
| act_drv | output | 1 | Pull traffic lamp pin low |
| col_drv | output | 1 | Pull collision lamp pin low |
| link_drv | output | 1 | Pull link lamp pin low |

## Verification
The embedded properties check on every cycle that a trigger lights its lamp on the next edge and reloads the full count. They also check that a running stretch counts down by exactly one, that an idle dark lamp stays dark, and that each branch of the link decode is followed one edge later. The bench scenarios cover what a single-cycle property cannot express. These are the exact pulse length of `STRETCH_CYC` cycles, the extension when a second event arrives partway through a stretch, a held trigger that never lets the lamp go dark, the independence of the two stretchers, and the lamp state while reset is held.

// File: rtl/net_led_pkg.sv
package net_led_pkg;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_ACT = 0;
  localparam int unsigned EVT_COL = 1;

  typedef enum logic {
    MEDIA_AUI = 1'b0,
    MEDIA_TP  = 1'b1
  } media_e;

  // Lamp decode for the link indicator; 1 means pull the pin low.
  function automatic logic link_lit(input logic fn_en, input media_e media,
                                    input logic test_en, input logic good);
    logic lit;
    if (!fn_en)                 lit = 1'b0;
    else if (media == MEDIA_AUI) lit = 1'b0;
    else if (!test_en)          lit = 1'b1;
    else                        lit = good;
    return lit;
  endfunction
endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned STRETCH_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic drv
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = trig | (cnt_q != '0);
    if (trig) cnt_d = LOAD;
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drv = (cnt_q != '0);

  // R2: a sampled trigger lights the lamp on the next edge
  p_trig_lights_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> drv);
  // R3: every trigger reloads the full length
  p_reload_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == LOAD));
  // R2: without triggers a running stretch counts down by one
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && drv) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R2: a dark lamp stays dark without a trigger
  p_idle_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !drv) |=> !drv);
endmodule

// File: rtl/link_led_dec.sv
module link_led_dec
  import net_led_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic media_tp,
  input  logic link_ok,
  input  logic link_test_en,
  input  logic link_led_en,
  output logic link_drv
);
  logic lit_d;
  logic lit_q;

  always_comb begin
    lit_d = link_lit(link_led_en, media_e'(media_tp), link_test_en, link_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lit_q <= 1'b0;
    else        lit_q <= lit_d;
  end

  assign link_drv = lit_q;

  p_aui_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !media_tp |=> !link_drv);
  p_tp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (media_tp && link_test_en && link_led_en) |=> (link_drv == $past(link_ok)));
  p_test_off_lit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (media_tp && !link_test_en && link_led_en) |=> link_drv);
  p_fn_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_led_en |=> !link_drv);
endmodule

// File: rtl/net_status_led.sv
module net_status_led
  import net_led_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_evt,
  input  logic rx_evt,
  input  logic col_evt,
  input  logic media_tp,
  input  logic link_ok,
  input  logic link_test_en,
  input  logic link_led_en,
  output logic act_drv,
  output logic col_drv,
  output logic link_drv
);
  logic [NUM_EVT-1:0] evt_trig;
  logic [NUM_EVT-1:0] evt_drv;

  always_comb begin
    evt_trig          = '0;
    evt_trig[EVT_ACT] = tx_evt | rx_evt;
    evt_trig[EVT_COL] = col_evt;
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    led_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (evt_trig[g]),
      .drv  (evt_drv[g])
    );
  end

  link_led_dec u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .media_tp    (media_tp),
    .link_ok     (link_ok),
    .link_test_en(link_test_en),
    .link_led_en (link_led_en),
    .link_drv    (link_drv)
  );

  assign act_drv = evt_drv[EVT_ACT];
  assign col_drv = evt_drv[EVT_COL];

  // R1: all lamps released in reset
  always_comb begin
    if (!rst_n) begin
      a_reset_dark_r1: assert (!link_drv);
    end
  end
  // R4: collision strobe alone never lights the traffic lamp
  p_col_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_evt && !tx_evt && !rx_evt && !act_drv) |=> !act_drv);
endmodule

// File: tb/sim_net_status_led.sv
module sim_net_status_led;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_evt = 1'b0, rx_evt = 1'b0, col_evt = 1'b0;
  logic media_tp = 1'b1, link_ok = 1'b0, link_test_en = 1'b1, link_led_en = 1'b1;
  logic act_drv, col_drv, link_drv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  net_status_led #(.STRETCH_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .rx_evt(rx_evt), .col_evt(col_evt),
    .media_tp(media_tp), .link_ok(link_ok), .link_test_en(link_test_en),
    .link_led_en(link_led_en), .act_drv(act_drv), .col_drv(col_drv), .link_drv(link_drv)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one-cycle pulse; returns at the negedge after the sampling edge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: tx_evt = 1'b1;
      1: rx_evt = 1'b1;
      default: col_evt = 1'b1;
    endcase
    @(negedge clk);
    tx_evt = 1'b0; rx_evt = 1'b0; col_evt = 1'b0;
  endtask

  task automatic t_reset;
    media_tp = 1'b1; link_test_en = 1'b0; link_led_en = 1'b1; tx_evt = 1'b1; col_evt = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 act", act_drv, 1'b0);
    check("R1 col", col_drv, 1'b0);
    check("R1 link", link_drv, 1'b0);
    tx_evt = 1'b0; col_evt = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 act after release", act_drv, 1'b0);
    check("R1 col after release", col_drv, 1'b0);
  endtask

  task automatic t_stretch(input int which, input logic tp, input string req);
    media_tp = tp;
    pulse(which);
    if (which == 2) check({req, " lit"}, col_drv, 1'b1);
    else            check({req, " lit"}, act_drv, 1'b1);
    if (which == 2) check("R4 traffic untouched", act_drv, 1'b0);
    else            check("R4 collision untouched", col_drv, 1'b0);
    repeat (S-1) @(negedge clk);
    if (which == 2) check({req, " last cycle"}, col_drv, 1'b1);
    else            check({req, " last cycle"}, act_drv, 1'b1);
    @(negedge clk);
    if (which == 2) check({req, " dark"}, col_drv, 1'b0);
    else            check({req, " dark"}, act_drv, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_retrigger;
    pulse(0);
    repeat (3) @(negedge clk);
    pulse(1);
    repeat (S-1) @(negedge clk);
    check("R3 extended still lit", act_drv, 1'b1);
    @(negedge clk);
    check("R3 extended dark", act_drv, 1'b0);
    @(negedge clk);
    rx_evt = 1'b1;
    for (int i = 0; i < 3*S; i++) begin
      @(negedge clk);
      check("R3 held trigger lit", act_drv, 1'b1);
    end
    rx_evt = 1'b0;
    repeat (S+2) @(negedge clk);
    check("R3 release dark", act_drv, 1'b0);
  endtask

  task automatic t_link;
    logic prev;
    @(negedge clk);
    prev = link_drv;
    for (int i = 0; i < 16; i++) begin
      logic exp;
      link_led_en = i[3]; media_tp = i[2]; link_test_en = i[1]; link_ok = i[0];
      if (!link_led_en)       exp = 1'b0; // R8
      else if (!media_tp)     exp = 1'b0; // R5
      else if (!link_test_en) exp = 1'b1; // R7
      else                    exp = link_ok; // R6
      #1 check("R9 not before edge", link_drv, prev);
      @(negedge clk);
      if (!link_led_en)       check("R8 link fn off", link_drv, exp);
      else if (!media_tp)     check("R5 aui dark", link_drv, exp);
      else if (!link_test_en) check("R7 test off lit", link_drv, exp);
      else                    check("R6 follows integrity", link_drv, exp);
      prev = exp;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stretch(0, 1'b1, "R2 tx tp");
    t_stretch(1, 1'b0, "R10 rx aui");
    t_stretch(2, 1'b1, "R4 col tp");
    t_stretch(2, 1'b0, "R10 col aui");
    t_retrigger();
    t_link();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule